// File: doc/BRIEF.md
# Four-Bit Skip-Flow Microcontroller Core

This block is a small 4-bit accumulator processor that fetches one 8-bit instruction byte per clock from an external program memory. It places the program counter on `pc_o` and expects the addressed byte on `instr_i` within the same cycle. The data RAM of 128 nibbles is inside the core. It is addressed by a pointer split into a 3-bit register-number part and a 4-bit digit-number part. A 4-bit adder serves the add-immediate instruction.

The core has no branch conditions. Conditional flow works through a skip flag instead. A test that comes out true, or an add that carries, sets the flag. The instruction fetched next is then still read, including its operand byte if it has one, but it changes nothing. The flag clears after that instruction.

The control is a three-state machine.
- `ST_EXEC` decodes an opcode byte.
- `ST_OPERAND` consumes the second byte of a two-byte instruction.
- `ST_DISCARD` consumes the second byte of a two-byte instruction that is being skipped.

It has these transitions:
- EXEC→EXEC: a one-byte instruction, executed or skipped.
- EXEC→OPERAND: an unskipped pointer load or jump.
- EXEC→DISCARD: a skipped pointer load or jump.
- OPERAND→EXEC: always.
- DISCARD→EXEC: always.

Top module: `nib_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to `ST_EXEC` with the program counter, accumulator, both pointer parts and the skip flag at zero, and `d_o` at zero.
- R2: Every clock consumes exactly one byte. The program counter rises by one (wrapping at 8 bits) on every edge, except the edge that completes a jump.
- R3: Opcode 0x1k (k = bits 3:0) adds k to the accumulator modulo 16. It sets the skip flag exactly when the add carries out of bit 3. No carry state is kept.
- R4: Opcode 0x20 is a two-byte pointer load. From the following byte, bits 6:4 go to the register number and bits 3:0 go to the digit number.
- R5: Opcode 0x21 drives the digit-number value onto `d_o` after the edge that executes it. At all other times `d_o` holds its value.
- R6: Opcode 0x22 loads the accumulator with `sin_i` in bit 0 and zeros in bits 3:1.
- R7: Opcode 0x23 writes the accumulator into the RAM nibble that the pointer selects.
- R8: Opcodes 0x30 to 0x33 test bit n (n = bits 1:0) of the addressed RAM nibble. They set the skip flag when that bit is zero.
- R9: Opcode 0x40 is a two-byte jump. The program counter is loaded with the following byte on the edge that consumes it.
- R10: When the skip flag is set, the next instruction and its operand byte, if it has one, are fetched but change no state. The flag is clear after that instruction.
- R11: Every opcode not listed above takes one cycle and changes nothing but the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 8 | Program memory address |
| instr_i | input | 8 | Program byte at `pc_o`, valid in the same cycle |
| sin_i | input | 1 | Serial input level |
| d_o | output | 4 | Registered D output port |

## Verification
The edge that executes the byte at address p is the edge that leaves p+1 on `pc_o`. An output instruction at p is therefore visible on `d_o` immediately after that edge. A skip decided at p suppresses the instruction at p+1, which completes one edge later, or two edges later if it has an operand byte. The bench counts edges from reset release and works out, for each checkpoint, the edge after which the expected program counter and port value must hold. It then samples on the following falling edge, half a cycle after the update. The effect of each skip is made visible by placing an output or pointer load where the skip would suppress it.

// File: rtl/nib_core_pkg.sv
package nib_core_pkg;

    localparam int NIB_W   = 4;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 3;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_EXEC    = 2'd0,
        ST_OPERAND = 2'd1,
        ST_DISCARD = 2'd2
    } core_state_e;

    localparam logic [BYTE_W-1:0] OP_LDPTR = 8'h20;
    localparam logic [BYTE_W-1:0] OP_OUTD  = 8'h21;
    localparam logic [BYTE_W-1:0] OP_RDSER = 8'h22;
    localparam logic [BYTE_W-1:0] OP_STORE = 8'h23;
    localparam logic [BYTE_W-1:0] OP_GOTO  = 8'h40;
    localparam logic [3:0]        GRP_ADDK = 4'h1;
    localparam logic [5:0]        GRP_TSTZ = 6'b001100;

    function automatic logic has_operand(input logic [BYTE_W-1:0] op);
        return (op == OP_LDPTR) || (op == OP_GOTO);
    endfunction

endpackage

// File: rtl/nib_adder.sv
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] full;

    assign full   = {1'b0, a_i} + {1'b0, b_i};
    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
endmodule

// File: rtl/nib_ram.sv
module nib_ram #(
    parameter int AW = 7,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [BYTE_W-1:0] pc_o,
    input  logic [BYTE_W-1:0] instr_i,
    input  logic              sin_i,
    output logic [NIB_W-1:0]  d_o
);
    localparam int RAM_AW = REG_W + DIGIT_W;

    core_state_e        state_q, state_d;
    logic [BYTE_W-1:0]  pc_q, pc_d;
    logic [NIB_W-1:0]   acc_q, acc_d;
    logic [REG_W-1:0]   br_q, br_d;
    logic [DIGIT_W-1:0] bd_q, bd_d;
    logic [NIB_W-1:0]   d_q, d_d;
    logic               skip_q, skip_d;
    logic               goto_q, goto_d;

    logic               ram_we;
    logic [NIB_W-1:0]   ram_rd;
    logic [NIB_W-1:0]   add_sum;
    logic               add_cout;

    nib_adder #(.W(NIB_W)) i_adder (
        .a_i    (acc_q),
        .b_i    (instr_i[NIB_W-1:0]),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    nib_ram #(.AW(RAM_AW), .DW(NIB_W)) i_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .addr_i  ({br_q, bd_q}),
        .wdata_i (acc_q),
        .rdata_o (ram_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EXEC;
            pc_q    <= '0;
            acc_q   <= '0;
            br_q    <= '0;
            bd_q    <= '0;
            d_q     <= '0;
            skip_q  <= 1'b0;
            goto_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            acc_q   <= acc_d;
            br_q    <= br_d;
            bd_q    <= bd_d;
            d_q     <= d_d;
            skip_q  <= skip_d;
            goto_q  <= goto_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q + 1'b1;
        acc_d   = acc_q;
        br_d    = br_q;
        bd_d    = bd_q;
        d_d     = d_q;
        skip_d  = skip_q;
        goto_d  = goto_q;
        ram_we  = 1'b0;
        unique case (state_q)
            ST_EXEC: begin
                if (skip_q) begin
                    skip_d = 1'b0;
                    if (has_operand(instr_i)) begin
                        state_d = ST_DISCARD;
                    end
                end else if (instr_i[7:4] == GRP_ADDK) begin
                    acc_d  = add_sum;
                    skip_d = add_cout;
                end else if (instr_i[7:2] == GRP_TSTZ) begin
                    skip_d = ~ram_rd[instr_i[1:0]];
                end else if (instr_i == OP_LDPTR) begin
                    state_d = ST_OPERAND;
                    goto_d  = 1'b0;
                end else if (instr_i == OP_GOTO) begin
                    state_d = ST_OPERAND;
                    goto_d  = 1'b1;
                end else if (instr_i == OP_OUTD) begin
                    d_d = bd_q;
                end else if (instr_i == OP_RDSER) begin
                    acc_d = {{(NIB_W-1){1'b0}}, sin_i};
                end else if (instr_i == OP_STORE) begin
                    ram_we = 1'b1;
                end
            end
            ST_OPERAND: begin
                state_d = ST_EXEC;
                if (goto_q) begin
                    pc_d = instr_i;
                end else begin
                    br_d = instr_i[6:4];
                    bd_d = instr_i[3:0];
                end
            end
            ST_DISCARD: begin
                state_d = ST_EXEC;
            end
            default: begin
                state_d = ST_EXEC;
            end
        endcase
    end

    // outputs
    always_comb begin
        pc_o = pc_q;
        d_o  = d_q;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && d_o == '0 && !skip_q && state_q == ST_EXEC));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_OPERAND && goto_q) |=> pc_o == BYTE_W'($past(pc_o) + 1'b1));

    p_d_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_EXEC && !skip_q && instr_i == OP_OUTD) |=> $stable(d_o));

    p_goto_target_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPERAND && goto_q) |=> pc_o == $past(instr_i));

    p_skip_once_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && skip_q) |=> !skip_q);

    p_skip_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && skip_q) |=>
            ($stable(acc_q) && $stable(br_q) && $stable(bd_q) && $stable(d_o)));

endmodule

// File: tb/test_nib_core.sv
module test_nib_core;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC      = 10;

    // {edge count after reset release, expected pc, expected d}
    localparam logic [19:0] VEC [N_VEC] = '{
        {8'd3,  8'h03, 4'h5},
        {8'd7,  8'h07, 4'h7},
        {8'd11, 8'h0B, 4'h7},
        {8'd16, 8'h10, 4'h7},
        {8'd22, 8'h16, 4'hA},
        {8'd27, 8'h1B, 4'hA},
        {8'd30, 8'h40, 4'hA},
        {8'd33, 8'h43, 4'hC},
        {8'd36, 8'h46, 4'hC},
        {8'd42, 8'h46, 4'hC}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pc;
    logic [7:0] instr;
    logic       sin = 1'b1;
    logic [3:0] d;
    logic [7:0] rom [256];
    int         edges = 0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    nib_core i_nib_core (
        .clk     (clk),
        .rst     (rst),
        .pc_o    (pc),
        .instr_i (instr),
        .sin_i   (sin),
        .d_o     (d)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    assign instr = rom[pc];

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2 R4 R5";
            1: return "R3 no-carry add";
            2: return "R3 R10 carry skip of two-byte load";
            3: return "R7 R8 zero bit skips";
            4: return "R6 R8 serial one, no skip";
            5: return "R10 skipped jump";
            6: return "R9 R3 jump taken";
            7: return "R5 output after jump";
            8: return "R11 unused opcodes";
            default: return "R9 R2 self loop";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) rom[a] = 8'h00;
        rom[0]  = 8'h20; rom[1]  = 8'h05;   // load pointer 0,5
        rom[2]  = 8'h21;                    // output -> 5
        rom[3]  = 8'h1F;                    // acc 0+15 = 15, no carry
        rom[4]  = 8'h20; rom[5]  = 8'h07;   // load pointer 0,7
        rom[6]  = 8'h21;                    // output -> 7
        rom[7]  = 8'h11;                    // acc 15+1 carries: skip
        rom[8]  = 8'h20; rom[9]  = 8'h03;   // skipped
        rom[10] = 8'h21;                    // output -> 7
        rom[11] = 8'h23;                    // store 0
        rom[12] = 8'h30;                    // bit0 zero: skip
        rom[13] = 8'h20; rom[14] = 8'h0A;   // skipped
        rom[15] = 8'h21;                    // output -> 7
        rom[16] = 8'h22;                    // acc = serial = 1
        rom[17] = 8'h23;                    // store 1
        rom[18] = 8'h30;                    // bit0 one: no skip
        rom[19] = 8'h20; rom[20] = 8'h2A;   // load pointer 2,A
        rom[21] = 8'h21;                    // output -> A
        rom[22] = 8'h20; rom[23] = 8'h07;   // load pointer 0,7
        rom[24] = 8'h31;                    // bit1 of 1 zero: skip
        rom[25] = 8'h40; rom[26] = 8'h00;   // skipped jump
        rom[27] = 8'h1E;                    // acc 1+14 = 15, no skip
        rom[28] = 8'h40; rom[29] = 8'h40;   // jump 0x40
        rom[30] = 8'h21;                    // must not run
        rom[64] = 8'h20; rom[65] = 8'h0C;   // load pointer 0,C
        rom[66] = 8'h21;                    // output -> C
        rom[67] = 8'hFF;                    // unused
        rom[68] = 8'h24;                    // unused
        rom[69] = 8'h21;                    // output -> C
        rom[70] = 8'h40; rom[71] = 8'h46;   // loop

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc, 8'h00);
        check("R1 reset d", {4'h0, d}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            wait (edges == int'(VEC[i][19:12]));
            @(negedge clk);
            check({vec_tag(i), " pc"}, pc, VEC[i][11:4]);
            check({vec_tag(i), " d"}, {4'h0, d}, {4'h0, VEC[i][3:0]});
        end

        // reset in mid-run clears pc and port
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset pc", pc, 8'h00);
        check("R1 mid-run reset d", {4'h0, d}, 8'h00);
        rst = 1'b0;
        // first output after restart reappears after edge 3
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 R5 restart output", {4'h0, d}, 8'h05);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule